// File: doc/BRIEF.md
# Filtered Translation-Cache Invalidation

This block is a small fully-associative cache of virtual-to-physical page translations for a 39-bit virtual address space. The space uses 27-bit virtual page numbers split into three 9-bit segments. An entry covers a 4 KiB, 2 MiB or 1 GiB page. Each entry carries an address-space tag, a global flag and a leaf flag. A non-leaf entry caches an intermediate table pointer that the walker can reuse. A lookup presents a page number and the current address-space tag and gets, in the same cycle, the matching entry's frame number, level and leaf flag. A page walker fills the cache, and slots are reused in round-robin order.

An invalidation request carries a virtual page number and an address-space tag. Each operand has a flag that marks it as the zero register, which means "all". The four flag combinations select which entries are cleared. Global entries are protected whenever a tag filter applies. A page-number filter touches leaf entries only. A page number that is not sign-extended from bit 38 turns the request into a no-op. The parameter `FLUSH_ALL` builds a variant that ignores both operands and clears every entry on any request.

All three request ports are valid/ready. `rf_ready` and `inv_ready` are held high, so the block never applies back-pressure. A request is taken in every cycle where its valid is high. A lookup is answered combinationally in the cycle it is presented.

Top module: `tlb_filtered`

## Requirements
- R1: A request with both zero flags set clears every entry: leaf and non-leaf, global or not, every tag.
- R2: A request with only the page number flagged zero clears every non-global entry, leaf or non-leaf, whose tag equals `inv_asid`. Global entries and entries with other tags stay.
- R3: A request with only the tag flagged zero clears every leaf entry whose page covers `inv_va_pn`, under any tag and including global entries. Non-leaf entries stay.
- R4: A request with neither flag set clears only non-global leaf entries whose page covers `inv_va_pn` and whose tag equals `inv_asid`.
- R5: An entry of level L (0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB) covers a page number when page-number bits 26 down to 9·L are equal. On a hit, `lk_ppn` takes its bits below 9·L from `lk_vpn` and the rest from the stored frame number.
- R6: When the page number is not flagged zero and bits 51..26 of `inv_va_pn` are not all equal, the request clears nothing.
- R7: Only the low `ASID_W` bits of any tag take part in a comparison. Higher bits are ignored.
- R8: With `FLUSH_ALL` set, every accepted invalidation clears every entry and drops a refill taken in the same cycle, whatever the operands are.
- R9: `rf_ready` and `inv_ready` are always high. `inv_done` is high in exactly the cycle after each cycle in which `inv_valid` is high, and it is low after reset.
- R10: A lookup in the same cycle as an invalidation sees the state after that invalidation.
- R11: Refills write slots 0, 1, 2, … in turn and wrap after the last one. Refill N+1 therefore overwrites the first slot.
- R12: A refill taken in the same cycle as an invalidation that would clear it is dropped, and the slot pointer does not advance. A refill the invalidation would not clear is written.
- R13: A lookup hits on a valid entry that covers `lk_vpn` and is either global or carries the low tag bits of `lk_asid`. When several entries match, the lowest slot wins. After reset, no lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 27 | Lookup virtual page number |
| lk_asid | input | ASID_MAX_W | Lookup address-space tag |
| lk_hit | output | 1 | Lookup hit |
| lk_leaf | output | 1 | Hit entry is a leaf |
| lk_lvl | output | 2 | Hit entry level |
| lk_ppn | output | 44 | Composed physical frame number |
| rf_valid | input | 1 | Refill request |
| rf_ready | output | 1 | Refill accepted (always high) |
| rf_vpn | input | 27 | Refill page number |
| rf_asid | input | ASID_MAX_W | Refill tag |
| rf_ppn | input | 44 | Refill frame number |
| rf_lvl | input | 2 | Refill level |
| rf_leaf | input | 1 | Refill is a leaf |
| rf_glob | input | 1 | Refill is global |
| inv_valid | input | 1 | Invalidation request |
| inv_ready | output | 1 | Invalidation accepted (always high) |
| inv_va_pn | input | XLEN-12 | Virtual address without page offset |
| inv_va_zero | input | 1 | Page-number operand is the zero register |
| inv_asid | input | ASID_MAX_W | Tag operand |
| inv_asid_zero | input | 1 | Tag operand is the zero register |
| inv_done | output | 1 | Invalidation completed pulse |

## Verification
On every cycle the assertions check the timing of the done pulse against accepted requests. They also check that a lookup never hits without a request, and that a full flush or any request in the flush-all variant leaves no hit in that cycle or the next. Which entries survive a filtered request can only be shown by the bench's scenarios. These cover global exemption, non-leaf retention, superpage coverage, tag truncation, non-canonical no-ops, round-robin eviction and refill collisions, all checked against a bench model.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
  localparam int VPN_W = 27;
  localparam int PPN_W = 44;
  localparam int SEG_W = 9;

  typedef struct packed {
    logic             leaf;
    logic             glob;
    logic [1:0]       lvl;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } ent_t;

  // Page-number bits that an entry of a given level compares.
  function automatic logic [VPN_W-1:0] vpn_mask(input logic [1:0] lvl);
    logic [VPN_W-1:0] m;
    m = '1;
    if (lvl >= 2'd1) m[SEG_W-1:0] = '0;
    if (lvl >= 2'd2) m[2*SEG_W-1:SEG_W] = '0;
    return m;
  endfunction
endpackage

// File: rtl/tlbf_kill.sv
module tlbf_kill
  import tlbf_pkg::*;
#(
  parameter int ASID_W    = 9,
  parameter bit FLUSH_ALL = 1'b0
) (
  input  logic              va_zero,
  input  logic              asid_zero,
  input  logic              va_ok,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic              e_leaf,
  input  logic              e_glob,
  input  logic [1:0]        e_lvl,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [ASID_W-1:0] e_asid,
  output logic              kill
);
  logic va_hit, as_hit, sel;

  always_comb begin
    va_hit = ((e_vpn ^ inv_vpn) & vpn_mask(e_lvl)) == '0;
    as_hit = (e_asid == inv_asid) && !e_glob;
    unique case ({va_zero, asid_zero})
      2'b11:   sel = 1'b1;
      2'b10:   sel = as_hit;
      2'b01:   sel = e_leaf && va_hit;
      default: sel = e_leaf && va_hit && as_hit;
    endcase
    kill = FLUSH_ALL ? 1'b1 : (va_ok && sel);
  end
endmodule

// File: rtl/tlbf_match.sv
module tlbf_match
  import tlbf_pkg::*;
#(
  parameter int ASID_W = 9
) (
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              e_glob,
  input  logic [1:0]        e_lvl,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [ASID_W-1:0] e_asid,
  output logic              hit
);
  always_comb
    hit = (((e_vpn ^ lk_vpn) & vpn_mask(e_lvl)) == '0) && (e_glob || (e_asid == lk_asid));
endmodule

// File: rtl/tlbf_rr.sv
module tlbf_rr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (adv)    ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tlb_filtered.sv
module tlb_filtered
  import tlbf_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int ASID_W     = 9,
  parameter int ASID_MAX_W = 16,
  parameter int XLEN       = 64,
  parameter int VA_W       = 39,
  parameter bit FLUSH_ALL  = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [VPN_W-1:0]      lk_vpn,
  input  logic [ASID_MAX_W-1:0] lk_asid,
  output logic                  lk_hit,
  output logic                  lk_leaf,
  output logic [1:0]            lk_lvl,
  output logic [PPN_W-1:0]      lk_ppn,
  input  logic                  rf_valid,
  output logic                  rf_ready,
  input  logic [VPN_W-1:0]      rf_vpn,
  input  logic [ASID_MAX_W-1:0] rf_asid,
  input  logic [PPN_W-1:0]      rf_ppn,
  input  logic [1:0]            rf_lvl,
  input  logic                  rf_leaf,
  input  logic                  rf_glob,
  input  logic                  inv_valid,
  output logic                  inv_ready,
  input  logic [XLEN-13:0]      inv_va_pn,
  input  logic                  inv_va_zero,
  input  logic [ASID_MAX_W-1:0] inv_asid,
  input  logic                  inv_asid_zero,
  output logic                  inv_done
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PN_W  = XLEN - 12;
  localparam int HI_W  = XLEN - VA_W + 1;
  localparam logic [ASID_MAX_W-1:0] ASID_KEEP =
    {{(ASID_MAX_W-ASID_W){1'b0}}, {ASID_W{1'b1}}};

  logic [ENTRIES-1:0] valid_q, eff_v, hit_v;
  ent_t               ent_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [ENTRIES:0]   kill_v;
  logic [IDX_W-1:0]   wr_ptr;
  logic [ASID_W-1:0]  lk_as, rf_as, inv_as;
  logic [HI_W-1:0]    va_hi;
  logic [VPN_W-1:0]   inv_vpn;
  logic               va_ok, rf_take;

  assign rf_ready  = 1'b1;
  assign inv_ready = 1'b1;
  assign lk_as     = ASID_W'(lk_asid & ASID_KEEP);
  assign rf_as     = ASID_W'(rf_asid & ASID_KEEP);
  assign inv_as    = ASID_W'(inv_asid & ASID_KEEP);
  assign va_hi     = inv_va_pn[PN_W-1:VPN_W-1];
  assign inv_vpn   = inv_va_pn[VPN_W-1:0];
  assign va_ok     = inv_va_zero || (&va_hi) || !(|va_hi);

  // One filter per stored entry plus one for the incoming refill.
  for (genvar i = 0; i <= ENTRIES; i++) begin : g_kill
    if (i < ENTRIES) begin : g_ent
      tlbf_kill #(.ASID_W(ASID_W), .FLUSH_ALL(FLUSH_ALL)) u_kill (
        .va_zero(inv_va_zero), .asid_zero(inv_asid_zero), .va_ok(va_ok),
        .inv_vpn(inv_vpn), .inv_asid(inv_as),
        .e_leaf(ent_q[i].leaf), .e_glob(ent_q[i].glob), .e_lvl(ent_q[i].lvl),
        .e_vpn(ent_q[i].vpn), .e_asid(asid_q[i]), .kill(kill_v[i]));
    end else begin : g_refill
      tlbf_kill #(.ASID_W(ASID_W), .FLUSH_ALL(FLUSH_ALL)) u_kill (
        .va_zero(inv_va_zero), .asid_zero(inv_asid_zero), .va_ok(va_ok),
        .inv_vpn(inv_vpn), .inv_asid(inv_as),
        .e_leaf(rf_leaf), .e_glob(rf_glob), .e_lvl(rf_lvl),
        .e_vpn(rf_vpn), .e_asid(rf_as), .kill(kill_v[i]));
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign eff_v[i] = valid_q[i] && !(inv_valid && kill_v[i]);
    logic raw_hit;
    tlbf_match #(.ASID_W(ASID_W)) u_match (
      .lk_vpn(lk_vpn), .lk_asid(lk_as),
      .e_glob(ent_q[i].glob), .e_lvl(ent_q[i].lvl),
      .e_vpn(ent_q[i].vpn), .e_asid(asid_q[i]), .hit(raw_hit));
    assign hit_v[i] = lk_valid && eff_v[i] && raw_hit;
  end

  // Lowest matching slot wins; superpage offset bits come from the request.
  always_comb begin
    lk_hit  = 1'b0;
    lk_leaf = 1'b0;
    lk_lvl  = '0;
    lk_ppn  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        lk_hit  = 1'b1;
        lk_leaf = ent_q[i].leaf;
        lk_lvl  = ent_q[i].lvl;
        lk_ppn  = (ent_q[i].ppn & {{(PPN_W-VPN_W){1'b1}}, vpn_mask(ent_q[i].lvl)})
                | {{(PPN_W-VPN_W){1'b0}}, lk_vpn & ~vpn_mask(ent_q[i].lvl)};
      end
    end
  end

  assign rf_take = rf_valid && !(inv_valid && kill_v[ENTRIES]);

  tlbf_rr #(.ENTRIES(ENTRIES)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(rf_take), .ptr(wr_ptr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      inv_done <= 1'b0;
    end else begin
      inv_done <= inv_valid;
      for (int i = 0; i < ENTRIES; i++)
        if (inv_valid && kill_v[i]) valid_q[i] <= 1'b0;
      if (rf_take) valid_q[wr_ptr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rf_take) begin
      ent_q[wr_ptr]  <= '{leaf: rf_leaf, glob: rf_glob, lvl: rf_lvl, vpn: rf_vpn, ppn: rf_ppn};
      asid_q[wr_ptr] <= rf_as;
    end
  end
endmodule

// File: rtl/tlbf_chk.sv
module tlbf_chk #(
  parameter bit FLUSH_ALL = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic inv_valid,
  input logic inv_va_zero,
  input logic inv_asid_zero,
  input logic inv_done,
  input logic lk_valid,
  input logic lk_hit
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> inv_done); // R9
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |-> $past(inv_valid)); // R9
  AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid); // R13
  AST_FULL_FLUSH_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_va_zero && inv_asid_zero) |-> !lk_hit); // R10
  AST_FULL_FLUSH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_va_zero && inv_asid_zero) |=> !lk_hit); // R1
  AST_FLUSH_ALL_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (FLUSH_ALL && inv_valid) |=> !lk_hit); // R8
endmodule

bind tlb_filtered tlbf_chk #(.FLUSH_ALL(FLUSH_ALL)) u_chk (
  .clk(clk), .rst_n(rst_n), .inv_valid(inv_valid), .inv_va_zero(inv_va_zero),
  .inv_asid_zero(inv_asid_zero), .inv_done(inv_done), .lk_valid(lk_valid), .lk_hit(lk_hit));

// File: tb/test_tlb_filtered.sv
`timescale 1ns/1ps
module test_tlb_filtered;
  localparam int N  = 8;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        lk_valid = 0, rf_valid = 0, inv_valid = 0;
  logic [26:0] lk_vpn = 0, rf_vpn = 0;
  logic [15:0] lk_asid = 0, rf_asid = 0, inv_asid = 0;
  logic [43:0] rf_ppn = 0;
  logic [1:0]  rf_lvl = 0;
  logic        rf_leaf = 0, rf_glob = 0, inv_va_zero = 0, inv_asid_zero = 0;
  logic [51:0] inv_va_pn = 0;

  logic        hit0, leaf0, rfr0, ivr0, done0;
  logic [1:0]  lvl0;
  logic [43:0] ppn0;
  logic        hit1, leaf1, rfr1, ivr1, done1;
  logic [1:0]  lvl1;
  logic [43:0] ppn1;

  tlb_filtered #(.FLUSH_ALL(1'b0)) i_tlb_filtered (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(hit0), .lk_leaf(leaf0), .lk_lvl(lvl0), .lk_ppn(ppn0),
    .rf_valid(rf_valid), .rf_ready(rfr0), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_ppn(rf_ppn),
    .rf_lvl(rf_lvl), .rf_leaf(rf_leaf), .rf_glob(rf_glob),
    .inv_valid(inv_valid), .inv_ready(ivr0), .inv_va_pn(inv_va_pn), .inv_va_zero(inv_va_zero),
    .inv_asid(inv_asid), .inv_asid_zero(inv_asid_zero), .inv_done(done0));

  tlb_filtered #(.FLUSH_ALL(1'b1)) i_tlb_filtered_fa (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(hit1), .lk_leaf(leaf1), .lk_lvl(lvl1), .lk_ppn(ppn1),
    .rf_valid(rf_valid), .rf_ready(rfr1), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_ppn(rf_ppn),
    .rf_lvl(rf_lvl), .rf_leaf(rf_leaf), .rf_glob(rf_glob),
    .inv_valid(inv_valid), .inv_ready(ivr1), .inv_va_pn(inv_va_pn), .inv_va_zero(inv_va_zero),
    .inv_asid(inv_asid), .inv_asid_zero(inv_asid_zero), .inv_done(done1));

  int n_checks = 0, n_err = 0;

  // Bench model: index 0 = filtered build, 1 = flush-all build.
  bit          mv  [2][N];
  bit          ml  [2][N];
  bit          mg  [2][N];
  logic [1:0]  mlv [2][N];
  logic [26:0] mvp [2][N];
  logic [8:0]  mas [2][N];
  logic [43:0] mpp [2][N];
  int          mptr[2];
  bit          exp_done = 0;

  function automatic logic [26:0] bmask(logic [1:0] l);
    if (l == 2'd0) return 27'h7ffffff;
    if (l == 2'd1) return 27'h7fffe00;
    return 27'h7fc0000;
  endfunction

  function automatic bit b_va_ok();
    if (inv_va_zero) return 1'b1;
    return (inv_va_pn[51:26] == '0) || (inv_va_pn[51:26] == '1);
  endfunction

  function automatic bit b_kill(int k, bit leaf, bit glob, logic [1:0] lvl,
                                logic [26:0] vpn, logic [8:0] as9);
    bit vh, ah;
    if (k == 1) return 1'b1;
    if (!b_va_ok()) return 1'b0;
    vh = ((vpn ^ inv_va_pn[26:0]) & bmask(lvl)) == '0;
    ah = (as9 == inv_asid[AW-1:0]) && !glob;
    if (inv_va_zero && inv_asid_zero) return 1'b1;
    if (inv_va_zero) return ah;
    if (inv_asid_zero) return leaf && vh;
    return leaf && vh && ah;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(string tag);
    #1;
    for (int k = 0; k < 2; k++) begin
      bit e_hit = 0;
      int e_i = 0;
      string t = (k == 1) ? "R8" : tag;
      for (int i = N - 1; i >= 0; i--) begin
        bit live = mv[k][i] && !(inv_valid && b_kill(k, ml[k][i], mg[k][i], mlv[k][i],
                                                      mvp[k][i], mas[k][i]));
        if (lk_valid && live && (((mvp[k][i] ^ lk_vpn) & bmask(mlv[k][i])) == '0)
            && (mg[k][i] || mas[k][i] == lk_asid[AW-1:0])) begin
          e_hit = 1;
          e_i = i;
        end
      end
      chk(t, "hit", (k == 0) ? hit0 : hit1, e_hit);
      if (e_hit) begin
        logic [26:0] m = bmask(mlv[k][e_i]);
        logic [43:0] ep = (mpp[k][e_i] & {17'h1ffff, m}) | {17'h0, lk_vpn & ~m};
        chk(t, "ppn", (k == 0) ? ppn0 : ppn1, ep);
        chk(t, "leaf", (k == 0) ? leaf0 : leaf1, ml[k][e_i]);
        chk(t, "lvl", (k == 0) ? lvl0 : lvl1, mlv[k][e_i]);
      end
    end
    chk("R9", "done", {done1, done0}, {exp_done, exp_done});
    chk("R9", "ready", {rfr0, ivr0, rfr1, ivr1}, 4'hf);
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      bit take = rf_valid && !(inv_valid && b_kill(k, rf_leaf, rf_glob, rf_lvl, rf_vpn, rf_asid[AW-1:0]));
      for (int i = 0; i < N; i++)
        if (inv_valid && b_kill(k, ml[k][i], mg[k][i], mlv[k][i], mvp[k][i], mas[k][i]))
          mv[k][i] = 0;
      if (take) begin
        mv[k][mptr[k]] = 1;  ml[k][mptr[k]] = rf_leaf; mg[k][mptr[k]] = rf_glob;
        mlv[k][mptr[k]] = rf_lvl; mvp[k][mptr[k]] = rf_vpn;
        mas[k][mptr[k]] = rf_asid[AW-1:0]; mpp[k][mptr[k]] = rf_ppn;
        mptr[k] = (mptr[k] + 1) % N;
      end
    end
    exp_done = inv_valid;
    @(negedge clk);
  endtask

  task automatic idle();
    lk_valid = 0; rf_valid = 0; inv_valid = 0;
  endtask
  task automatic rf(logic [26:0] v, logic [15:0] a, logic [43:0] p, logic [1:0] l, bit lf, bit g);
    rf_valid = 1; rf_vpn = v; rf_asid = a; rf_ppn = p; rf_lvl = l; rf_leaf = lf; rf_glob = g;
  endtask
  task automatic iv(bit vz, logic [51:0] va, bit az, logic [15:0] a);
    inv_valid = 1; inv_va_zero = vz; inv_va_pn = va; inv_asid_zero = az; inv_asid = a;
  endtask
  task automatic lk(logic [26:0] v, logic [15:0] a);
    lk_valid = 1; lk_vpn = v; lk_asid = a;
  endtask

  function automatic string auto_tag();
    if (!inv_valid) return rf_valid ? "R11" : "R13";
    if (!b_va_ok()) return "R6";
    if (inv_va_zero && inv_asid_zero) return "R1";
    if (inv_va_zero) return "R2";
    if (inv_asid_zero) return "R3";
    return "R4";
  endfunction

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    mptr[0] = 0; mptr[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // Reset state: nothing hits, no done pulse.
    lk(27'h0, 16'h0); cycle("R13");

    // R5: 2 MiB and 1 GiB pages cover their range and compose the frame.
    idle(); rf({9'h40, 9'h05, 9'h00}, 16'h1, 44'h123_4567_89ab, 2'd1, 1, 0); cycle("R11");
    idle(); lk({9'h40, 9'h05, 9'h1f}, 16'h1); cycle("R5");
    idle(); rf({9'h41, 9'h00, 9'h00}, 16'h1, 44'hfed_cba9_8765, 2'd2, 1, 0); cycle("R11");
    idle(); lk({9'h41, 9'h33, 9'h77}, 16'h1); cycle("R5");
    idle(); lk({9'h40, 9'h06, 9'h1f}, 16'h1); cycle("R5");

    // R7: tag bits above the implemented width are ignored.
    idle(); rf({9'h42, 9'h01, 9'h02}, 16'h0005, 44'h111, 2'd0, 1, 0); cycle("R11");
    idle(); lk({9'h42, 9'h01, 9'h02}, 16'hfe05); cycle("R7");
    idle(); lk({9'h42, 9'h01, 9'h02}, 16'h0006); cycle("R13");
    idle(); rf({9'h42, 9'h01, 9'h03}, 16'h0003, 44'h222, 2'd0, 1, 1); cycle("R11");
    idle(); lk({9'h42, 9'h01, 9'h03}, 16'h0007); cycle("R13");

    // R3: VA-only flush keeps non-leaf entries.
    idle(); rf({9'h43, 9'h00, 9'h00}, 16'h2, 44'h333, 2'd1, 0, 0); cycle("R11");
    idle(); iv(0, {25'h0, 9'h43, 9'h00, 9'h00}, 1, 16'h0); cycle("R3");
    idle(); lk({9'h43, 9'h00, 9'h10}, 16'h2); cycle("R3");

    // R6: non-canonical VA clears nothing.
    idle(); rf({9'h44, 9'h00, 9'h01}, 16'h2, 44'h444, 2'd0, 1, 0); cycle("R11");
    idle(); iv(0, {1'b1, 24'h0, 9'h44, 9'h00, 9'h01}, 1, 16'h0); cycle("R6");
    idle(); lk({9'h44, 9'h00, 9'h01}, 16'h2); cycle("R6");

    // R10: lookup sees same-cycle full flush.
    idle(); iv(1, 52'h0, 1, 16'h0); lk({9'h44, 9'h00, 9'h01}, 16'h2); cycle("R10");
    idle(); lk({9'h40, 9'h05, 9'h00}, 16'h1); cycle("R1");

    // R12: refill colliding with a matching / non-matching invalidation.
    idle(); rf({9'h45, 9'h0, 9'h0}, 16'h4, 44'h555, 2'd0, 1, 0); iv(1, 52'h0, 0, 16'h4); cycle("R12");
    idle(); lk({9'h45, 9'h0, 9'h0}, 16'h4); cycle("R12");
    idle(); rf({9'h45, 9'h0, 9'h0}, 16'h4, 44'h556, 2'd0, 1, 0); iv(1, 52'h0, 0, 16'h9); cycle("R12");
    idle(); lk({9'h45, 9'h0, 9'h0}, 16'h4); cycle("R12");

    // R2: tag-only flush spares globals and other tags.
    idle(); rf({9'h46, 9'h0, 9'h1}, 16'h5, 44'h661, 2'd0, 1, 0); cycle("R11");
    idle(); rf({9'h46, 9'h0, 9'h2}, 16'h5, 44'h662, 2'd0, 1, 1); cycle("R11");
    idle(); rf({9'h46, 9'h0, 9'h3}, 16'h6, 44'h663, 2'd0, 1, 0); cycle("R11");
    idle(); iv(1, 52'h0, 0, 16'h5); cycle("R2");
    for (int j = 1; j <= 3; j++) begin
      idle(); lk({9'h46, 9'h0, 9'(j)}, (j == 3) ? 16'h6 : 16'h5); cycle("R2");
    end

    // R4: VA+tag flush clears only the matching tag.
    idle(); rf({9'h47, 9'h0, 9'h0}, 16'h7, 44'h771, 2'd0, 1, 0); cycle("R11");
    idle(); rf({9'h47, 9'h0, 9'h0}, 16'h8, 44'h772, 2'd0, 1, 0); cycle("R11");
    idle(); iv(0, {25'h0, 9'h47, 9'h0, 9'h0}, 0, 16'h7); cycle("R4");
    idle(); lk({9'h47, 9'h0, 9'h0}, 16'h7); cycle("R4");
    idle(); lk({9'h47, 9'h0, 9'h0}, 16'h8); cycle("R4");

    // R11: N+1 refills evict the oldest slot.
    idle(); iv(1, 52'h0, 1, 16'h0); cycle("R1");
    for (int j = 0; j <= N; j++) begin
      idle(); rf({9'h48, 9'(j), 9'h0}, 16'h1, 44'(j), 2'd0, 1, 0); cycle("R11");
    end
    idle(); lk({9'h48, 9'h0, 9'h0}, 16'h1); cycle("R11");
    idle(); lk({9'h48, 9'h1, 9'h0}, 16'h1); cycle("R11");

    // Constrained random mix.
    for (int c = 0; c < 4000; c++) begin
      logic [26:0] v;
      idle();
      if ($urandom % 3 == 0) begin
        v = {9'h40 + 9'($urandom % 3), 9'($urandom % 3), 9'($urandom % 4)};
        rf(v, {7'($urandom), 9'($urandom % 3)}, {$urandom, 12'($urandom)},
           2'($urandom % 3), ($urandom % 5) != 0, ($urandom % 4) == 0);
      end
      if ($urandom % 6 == 0) begin
        v = {9'h40 + 9'($urandom % 3), 9'($urandom % 3), 9'($urandom % 4)};
        iv($urandom % 2, ($urandom % 8 == 0) ? {1'b1, 24'h0, v} : {25'h0, v},
           $urandom % 2, {7'($urandom), 9'($urandom % 3)});
      end
      if ($urandom % 2 == 0)
        lk({9'h40 + 9'($urandom % 3), 9'($urandom % 3), 9'($urandom % 4)},
           {7'($urandom), 9'($urandom % 3)});
      cycle(auto_tag());
    end
    idle(); cycle("R13");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule